// File: doc/BRIEF.md
# Cacheline Channel Request Translator

This block is one memory-access channel that sits between a processor cache port and a shared memory-controller port. The cache side submits requests (read or write, address, transfer size) through a valid/ready handshake into a four-entry access buffer. A sequencer takes one entry at a time and turns it into a series of memory beats. Each beat carries an address, a size code, byte enables and a write flag, and is held until the memory side acknowledges it.

The shape of the traffic is fixed by parameters when the channel is built. Reads always fetch a whole cache line of `LINE_WORDS` words. `WR_MODE` selects one of three write behaviours: writes are rejected, each write is a single sub-word or word transfer, or each write is a full line of `WR_LINE_WORDS` words. Write data comes from a separate valid/ready stream, one word per write beat. Read data returns to the cache side either combinationally in the cycle of the memory acknowledge (`RDBUF_DEPTH` = 0) or through a small FIFO that adds one cycle. The cache side has no read backpressure and takes each word as it arrives.

Top module: `cline_channel`

## Requirements
- R1: A read request produces `LINE_WORDS` beats. The first beat is at the request address rounded down to a line boundary (`LINE_WORDS`*4 bytes), and each later beat is 4 bytes above the one before. Every read beat has byte enables 4'b1111 and size code 2 (word). `rsp_last` is high with the final word only.
- R2: With `WR_MODE` = 2, a write request produces `WR_LINE_WORDS` beats from the address rounded down to a `WR_LINE_WORDS`*4-byte boundary, incrementing by 4. Each beat has byte enables 4'b1111 and size code 2 and carries the next word of the write-data stream, whatever size the request carried.
- R3: With `WR_MODE` = 1, a write request produces exactly one beat at the unmodified request address, with the request's size code (0 byte, 1 half-word, 2 word). Byte enables are 4'b0001 shifted left by addr[1:0] for a byte, 4'b0011 or 4'b1100 chosen by addr[1] for a half-word, and 4'b1111 for a word.
- R4: With `WR_MODE` = 0, a write request is removed from the access buffer without ever asserting `mem_req` with `mem_we`. It sets `wr_err`, which stays high until reset, and later reads are still served.
- R5: The access buffer holds 4 entries. `req_ready` is low while it is full, and requests are served in arrival order.
- R6: With `RDBUF_DEPTH` = 0, `rsp_valid` is high in exactly the cycles where a read beat is acknowledged, and carries `mem_rdata` of that cycle.
- R7: With `RDBUF_DEPTH` > 0, each acknowledged read word appears on `rsp_data` exactly one cycle after its acknowledge, in order.
- R8: `wr_done` pulses for one cycle in the cycle after the final beat of a write is acknowledged.
- R9: Once raised, `mem_req` stays high with `mem_addr`, `mem_be` and `mem_we` unchanged until `mem_ack`.
- R10: After reset, `req_ready` is high and `mem_req`, `rsp_valid`, `wr_done` and `wr_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Cache request valid |
| req_ready | output | 1 | Access buffer has room |
| req_wr | input | 1 | 1 = write request, 0 = line read |
| req_size | input | 2 | Single-write size code: 0 byte, 1 half, 2 word |
| req_addr | input | 32 | Byte address of the request |
| wd_valid | input | 1 | Write-data word valid |
| wd_ready | output | 1 | Write-data word taken this cycle |
| wd_data | input | 32 | Write-data word |
| rsp_valid | output | 1 | Read word valid toward the cache |
| rsp_data | output | 32 | Read word |
| rsp_last | output | 1 | Final word of a line read |
| wr_done | output | 1 | One-cycle pulse: a write finished |
| wr_err | output | 1 | Sticky: a write was rejected |
| mem_req | output | 1 | Memory beat request |
| mem_ack | input | 1 | Memory beat acknowledge |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | 32 | Beat byte address |
| mem_size | output | 2 | Beat size code |
| mem_be | output | 4 | Beat byte enables |
| mem_wdata | output | 32 | Beat write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` on a read beat |

## Verification
The hold property for `mem_req` assumes the write-data source keeps `wd_valid` high once it is raised, until the word is taken, because a write beat is only offered while a word is present. The bench queues each write word before it issues the matching request and never withdraws one. The pass-through read path assumes the cache side accepts a word in every cycle, which fits a port that has no ready signal. The bench acknowledges beats only through its own stall pattern and reads every returned word.

// File: rtl/cline_pkg.sv
package cline_pkg;
    parameter int unsigned ADDR_W = 32;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned BE_W   = DATA_W / 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } xsize_e;

    typedef struct packed {
        logic              wr;
        xsize_e            size;
        logic [ADDR_W-1:0] addr;
    } acc_entry_t;

    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_RUN  = 1'b1
    } ch_state_e;
endpackage

// File: rtl/cline_fifo.sv
module cline_fifo #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             full,
    output logic             empty
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [CNT_W-1:0] cnt;
    } fifo_st_t;

    fifo_st_t s_d, s_q;
    logic [WIDTH-1:0] store_q [DEPTH];

    function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        s_d = s_q;
        if (push) s_d.wp = wrap_inc(s_q.wp);
        if (pop)  s_d.rp = wrap_inc(s_q.rp);
        case ({push, pop})
            2'b10:   s_d.cnt = s_q.cnt + CNT_W'(1);
            2'b01:   s_d.cnt = s_q.cnt - CNT_W'(1);
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (push) store_q[s_q.wp] <= wdata;
    end

    assign full  = (s_q.cnt == CNT_W'(DEPTH));
    assign empty = (s_q.cnt == '0);
    assign rdata = store_q[s_q.rp];

    // R5: the producer never writes into a full buffer
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R5: the consumer never reads an empty buffer
    a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CNT_W'(DEPTH));
endmodule

// File: rtl/cline_lane_map.sv
module cline_lane_map
    import cline_pkg::*;
(
    input  xsize_e           size,
    input  logic [1:0]       lsb,
    input  logic             full_word,
    output logic [BE_W-1:0]  be
);
    always_comb begin
        if (full_word || size == SZ_WORD) begin
            be = '1;
        end else if (size == SZ_HALF) begin
            be = lsb[1] ? 4'b1100 : 4'b0011;
        end else begin
            be = 4'b0001 << lsb;
        end
    end
endmodule

// File: rtl/cline_beat_seq.sv
module cline_beat_seq
    import cline_pkg::*;
#(
    parameter int unsigned CNT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  logic [CNT_W-1:0]  beats,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  left;
    } seq_st_t;

    seq_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.addr = base;
            s_d.left = beats - CNT_W'(1);
        end else if (step) begin
            s_d.addr = s_q.addr + ADDR_W'(4);
            s_d.left = s_q.left - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign addr = s_q.addr;
    assign last = (s_q.left == '0);

    // R1/R2: consecutive beats of a burst are one word apart
    a_r1_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !last && !load) |=> addr == $past(addr) + ADDR_W'(4));
endmodule

// File: rtl/cline_channel.sv
module cline_channel
    import cline_pkg::*;
#(
    parameter int unsigned LINE_WORDS    = 8,
    parameter int unsigned WR_LINE_WORDS = 4,
    parameter int unsigned WR_MODE       = 2,
    parameter int unsigned RDBUF_DEPTH   = 0,
    parameter int unsigned REQ_DEPTH     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_wr,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              wd_valid,
    output logic              wd_ready,
    input  logic [DATA_W-1:0] wd_data,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_last,
    output logic              wr_done,
    output logic              wr_err,
    output logic              mem_req,
    input  logic              mem_ack,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic [BE_W-1:0]   mem_be,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int unsigned MAX_BEATS = (LINE_WORDS > WR_LINE_WORDS) ? LINE_WORDS : WR_LINE_WORDS;
    localparam int unsigned CNT_W     = $clog2(MAX_BEATS + 1);
    localparam int unsigned RD_LSB    = $clog2(LINE_WORDS * 4);
    localparam int unsigned WR_LSB    = $clog2(WR_LINE_WORDS * 4);
    localparam int unsigned ENTRY_W   = $bits(acc_entry_t);

    typedef struct packed {
        ch_state_e       st;
        logic            we;
        xsize_e          size;
        logic [BE_W-1:0] be;
        logic            done;
        logic            err;
    } ctl_t;

    ctl_t c_d, c_q;

    // access buffer
    logic               acc_full, acc_empty, acc_pop, acc_push;
    logic [ENTRY_W-1:0] head_raw;
    acc_entry_t         head, in_entry;

    assign in_entry  = '{wr: req_wr, size: xsize_e'(req_size), addr: req_addr};
    assign acc_push  = req_valid && !acc_full;
    assign req_ready = !acc_full;
    assign head      = acc_entry_t'(head_raw);

    cline_fifo #(.WIDTH(ENTRY_W), .DEPTH(REQ_DEPTH)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (acc_push),
        .wdata (ENTRY_W'(in_entry)),
        .pop   (acc_pop),
        .rdata (head_raw),
        .full  (acc_full),
        .empty (acc_empty)
    );

    // byte lanes for the head entry
    logic [BE_W-1:0] lane_be;
    cline_lane_map u_lane (
        .size      (head.size),
        .lsb       (head.addr[1:0]),
        .full_word (!head.wr || (WR_MODE == 2)),
        .be        (lane_be)
    );

    // beat sequencer
    logic              seq_load, seq_last, beat_hs;
    logic [ADDR_W-1:0] seq_base, seq_addr;
    logic [CNT_W-1:0]  seq_beats;

    cline_beat_seq #(.CNT_W(CNT_W)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (seq_load),
        .base  (seq_base),
        .beats (seq_beats),
        .step  (beat_hs),
        .addr  (seq_addr),
        .last  (seq_last)
    );

    always_comb begin
        c_d       = c_q;
        c_d.done  = 1'b0;
        acc_pop   = 1'b0;
        seq_load  = 1'b0;
        seq_base  = head.addr;
        seq_beats = CNT_W'(1);
        case (c_q.st)
            CH_IDLE: begin
                if (!acc_empty) begin
                    acc_pop = 1'b1;
                    if (head.wr && (WR_MODE == 0)) begin
                        c_d.err = 1'b1;
                    end else begin
                        seq_load = 1'b1;
                        c_d.st   = CH_RUN;
                        c_d.we   = head.wr;
                        c_d.be   = lane_be;
                        if (!head.wr) begin
                            seq_base  = {head.addr[ADDR_W-1:RD_LSB], {RD_LSB{1'b0}}};
                            seq_beats = CNT_W'(LINE_WORDS);
                            c_d.size  = SZ_WORD;
                        end else if (WR_MODE == 2) begin
                            seq_base  = {head.addr[ADDR_W-1:WR_LSB], {WR_LSB{1'b0}}};
                            seq_beats = CNT_W'(WR_LINE_WORDS);
                            c_d.size  = SZ_WORD;
                        end else begin
                            seq_base  = head.addr;
                            seq_beats = CNT_W'(1);
                            c_d.size  = head.size;
                        end
                    end
                end
            end
            CH_RUN: begin
                if (beat_hs && seq_last) begin
                    c_d.st   = CH_IDLE;
                    c_d.done = c_q.we;
                end
            end
            default: c_d.st = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '{st: CH_IDLE, we: 1'b0, size: SZ_WORD, be: '0, done: 1'b0, err: 1'b0};
        end else begin
            c_q <= c_d;
        end
    end

    // memory side
    assign mem_req   = (c_q.st == CH_RUN) && (!c_q.we || wd_valid);
    assign beat_hs   = mem_req && mem_ack;
    assign mem_we    = c_q.we;
    assign mem_addr  = seq_addr;
    assign mem_size  = c_q.size;
    assign mem_be    = c_q.be;
    assign mem_wdata = wd_data;
    assign wd_ready  = (c_q.st == CH_RUN) && c_q.we && mem_ack;
    assign wr_done   = c_q.done;
    assign wr_err    = c_q.err;

    // read return path
    logic rd_hs, rd_last;
    assign rd_hs   = beat_hs && !c_q.we;
    assign rd_last = rd_hs && seq_last;

    generate
        if (RDBUF_DEPTH == 0) begin : g_rd_pass
            assign rsp_valid = rd_hs;
            assign rsp_data  = mem_rdata;
            assign rsp_last  = rd_last;
        end else begin : g_rd_buf
            logic              rb_full, rb_empty;
            logic [DATA_W:0]   rb_out;
            cline_fifo #(.WIDTH(DATA_W + 1), .DEPTH(RDBUF_DEPTH)) u_rbuf (
                .clk   (clk),
                .rst_n (rst_n),
                .push  (rd_hs),
                .wdata ({rd_last, mem_rdata}),
                .pop   (!rb_empty),
                .rdata (rb_out),
                .full  (rb_full),
                .empty (rb_empty)
            );
            assign rsp_valid = !rb_empty;
            assign rsp_data  = rb_out[DATA_W-1:0];
            assign rsp_last  = rb_out[DATA_W];

            // R7: the buffer drains every cycle, so it always has room
            a_r7_buf_room: assert property (@(posedge clk) disable iff (!rst_n)
                rd_hs |-> !rb_full);
        end

        if (WR_MODE == 0) begin : g_chk_nowr
            a_r4_no_write_beat: assert property (@(posedge clk) disable iff (!rst_n)
                mem_req |-> !mem_we);
        end
        if (WR_MODE == 2) begin : g_chk_linewr
            a_r2_line_full_word: assert property (@(posedge clk) disable iff (!rst_n)
                (mem_req && mem_we) |-> (mem_be == '1 && mem_size == 2'(SZ_WORD)));
        end
    endgenerate

    // R9: an offered beat is held until it is acknowledged
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_be) && $stable(mem_we)));
    // R4: the rejection flag never clears
    a_r4_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |=> wr_err);
    // R1: read beats are word sized with all lanes on
    a_r1_read_full_word: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> (mem_be == '1 && mem_size == 2'(SZ_WORD)));
    // R8: completion follows an acknowledged write beat
    a_r8_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |-> $past(mem_req && mem_ack && mem_we));
    // R8: completion is a single-cycle pulse for single-beat spacing
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> !wr_done);
endmodule

// File: tb/sim_cline_channel.sv
module sim_cline_channel;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic        req_valid [3];
    logic        req_ready [3];
    logic        req_wr    [3];
    logic [1:0]  req_size  [3];
    logic [31:0] req_addr  [3];
    logic        wd_valid  [3];
    logic        wd_ready  [3];
    logic [31:0] wd_data   [3];
    logic        rsp_valid [3];
    logic [31:0] rsp_data  [3];
    logic        rsp_last  [3];
    logic        wr_done   [3];
    logic        wr_err    [3];
    logic        mem_req   [3];
    logic        mem_ack   [3];
    logic        mem_we    [3];
    logic [31:0] mem_addr  [3];
    logic [1:0]  mem_size  [3];
    logic [3:0]  mem_be    [3];
    logic [31:0] mem_wdata [3];
    logic [31:0] mem_rdata [3];

    cline_channel #(.LINE_WORDS(8), .WR_LINE_WORDS(4), .WR_MODE(2), .RDBUF_DEPTH(0)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid[0]), .req_ready(req_ready[0]), .req_wr(req_wr[0]),
        .req_size(req_size[0]), .req_addr(req_addr[0]),
        .wd_valid(wd_valid[0]), .wd_ready(wd_ready[0]), .wd_data(wd_data[0]),
        .rsp_valid(rsp_valid[0]), .rsp_data(rsp_data[0]), .rsp_last(rsp_last[0]),
        .wr_done(wr_done[0]), .wr_err(wr_err[0]),
        .mem_req(mem_req[0]), .mem_ack(mem_ack[0]), .mem_we(mem_we[0]),
        .mem_addr(mem_addr[0]), .mem_size(mem_size[0]), .mem_be(mem_be[0]),
        .mem_wdata(mem_wdata[0]), .mem_rdata(mem_rdata[0]));

    cline_channel #(.LINE_WORDS(4), .WR_LINE_WORDS(4), .WR_MODE(1), .RDBUF_DEPTH(2)) u1 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid[1]), .req_ready(req_ready[1]), .req_wr(req_wr[1]),
        .req_size(req_size[1]), .req_addr(req_addr[1]),
        .wd_valid(wd_valid[1]), .wd_ready(wd_ready[1]), .wd_data(wd_data[1]),
        .rsp_valid(rsp_valid[1]), .rsp_data(rsp_data[1]), .rsp_last(rsp_last[1]),
        .wr_done(wr_done[1]), .wr_err(wr_err[1]),
        .mem_req(mem_req[1]), .mem_ack(mem_ack[1]), .mem_we(mem_we[1]),
        .mem_addr(mem_addr[1]), .mem_size(mem_size[1]), .mem_be(mem_be[1]),
        .mem_wdata(mem_wdata[1]), .mem_rdata(mem_rdata[1]));

    cline_channel #(.LINE_WORDS(4), .WR_LINE_WORDS(4), .WR_MODE(0), .RDBUF_DEPTH(0)) u2 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid[2]), .req_ready(req_ready[2]), .req_wr(req_wr[2]),
        .req_size(req_size[2]), .req_addr(req_addr[2]),
        .wd_valid(wd_valid[2]), .wd_ready(wd_ready[2]), .wd_data(wd_data[2]),
        .rsp_valid(rsp_valid[2]), .rsp_data(rsp_data[2]), .rsp_last(rsp_last[2]),
        .wr_done(wr_done[2]), .wr_err(wr_err[2]),
        .mem_req(mem_req[2]), .mem_ack(mem_ack[2]), .mem_we(mem_we[2]),
        .mem_addr(mem_addr[2]), .mem_size(mem_size[2]), .mem_be(mem_be[2]),
        .mem_wdata(mem_wdata[2]), .mem_rdata(mem_rdata[2]));

    typedef struct {
        bit          is_wr;
        logic [31:0] addr;
        logic [3:0]  be;
        logic [1:0]  size;
        logic [31:0] data;
        bit          last;
        string       tag;
    } exp_t;

    exp_t        exp_q[$];
    logic [31:0] wd_q[$];
    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    int done_cnt [3];
    bit ack_en  = 1'b1;
    bit finished = 1'b0;
    bit prev_rhs [3];
    bit prev_wlast [3];

    function automatic logic [31:0] rd_model(input logic [31:0] a);
        return {a[15:0] ^ 16'h5A3C, a[15:0]};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // memory responder and write-data source
    always @(negedge clk) begin
        cyc++;
        for (int k = 0; k < 3; k++) begin
            mem_ack[k]   = ack_en && (cyc % 3 != 2);
            mem_rdata[k] = rd_model(mem_addr[k]);
            wd_valid[k]  = (wd_q.size() > 0);
            wd_data[k]   = (wd_q.size() > 0) ? wd_q[0] : 32'h0;
        end
        #2;
        for (int k = 0; k < 3; k++) begin
            if (wd_valid[k] && wd_ready[k] && wd_q.size() > 0) void'(wd_q.pop_front());
        end
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        exp_t it;
        bit rhs, whs, wl;
        #2;
        if (rst_n) begin
            for (int k = 0; k < 3; k++) begin
                rhs = mem_req[k] && mem_ack[k] && !mem_we[k];
                whs = mem_req[k] && mem_ack[k] && mem_we[k];
                wl  = 1'b0;
                if (rhs)
                    chk(mem_be[k] == 4'hF && mem_size[k] == 2'd2, "R1", "read beat be/size",
                        {26'd0, mem_size[k], mem_be[k]}, 32'h2F);
                if (k == 1) begin
                    if (rsp_valid[1] || prev_rhs[1])
                        chk(rsp_valid[1] == prev_rhs[1], "R7", "buffered read latency",
                            32'(rsp_valid[1]), 32'(prev_rhs[1]));
                end else if (rsp_valid[k] || rhs) begin
                    chk(rsp_valid[k] == rhs, "R6", "pass-through read timing",
                        32'(rsp_valid[k]), 32'(rhs));
                    if (rhs) chk(rsp_data[k] == mem_rdata[k], "R6", "pass-through data",
                                 rsp_data[k], mem_rdata[k]);
                end
                if (rsp_valid[k]) begin
                    if (exp_q.size() == 0) chk(1'b0, "R1", "unexpected read word", rsp_data[k], 32'h0);
                    else begin
                        it = exp_q.pop_front();
                        chk(!it.is_wr && rsp_data[k] == it.data, it.tag, "read word",
                            rsp_data[k], it.data);
                        chk(rsp_last[k] == it.last, "R1", "rsp_last",
                            32'(rsp_last[k]), 32'(it.last));
                    end
                end
                if (whs) begin
                    if (k == 2) chk(1'b0, "R4", "write beat in no-write mode", mem_addr[k], 32'h0);
                    if (exp_q.size() == 0) chk(1'b0, "R2", "unexpected write beat", mem_addr[k], 32'h0);
                    else begin
                        it = exp_q.pop_front();
                        chk(it.is_wr && mem_addr[k] == it.addr, it.tag, "write address", mem_addr[k], it.addr);
                        chk(mem_be[k] == it.be && mem_size[k] == it.size, it.tag, "write be/size",
                            {26'd0, mem_size[k], mem_be[k]}, {26'd0, it.size, it.be});
                        chk(mem_wdata[k] == it.data, it.tag, "write data", mem_wdata[k], it.data);
                        wl = it.last;
                    end
                end
                if (wr_done[k] || prev_wlast[k])
                    chk(wr_done[k] == prev_wlast[k], "R8", "wr_done timing",
                        32'(wr_done[k]), 32'(prev_wlast[k]));
                if (wr_done[k]) done_cnt[k]++;
                prev_rhs[k]   = rhs;
                prev_wlast[k] = wl;
            end
        end
    end

    task automatic exp_read(input logic [31:0] base, input int n);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back('{is_wr: 1'b0, addr: base + 32'(4 * i), be: 4'hF, size: 2'd2,
                              data: rd_model(base + 32'(4 * i)), last: (i == n - 1), tag: "R1"});
        end
    endtask

    task automatic exp_write(input logic [31:0] a, input logic [3:0] be, input logic [1:0] sz,
                             input logic [31:0] d, input bit last, input string tag);
        exp_q.push_back('{is_wr: 1'b1, addr: a, be: be, size: sz, data: d, last: last, tag: tag});
        wd_q.push_back(d);
    endtask

    task automatic send_req(input int k, input bit wr, input logic [1:0] sz, input logic [31:0] a);
        @(negedge clk);
        req_valid[k] = 1'b1;
        req_wr[k]    = wr;
        req_size[k]  = sz;
        req_addr[k]  = a;
        #2;
        while (!req_ready[k]) begin
            @(negedge clk);
            #2;
        end
        @(posedge clk);
        #1;
        req_valid[k] = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        logic [31:0] a0;
        for (int k = 0; k < 3; k++) begin
            req_valid[k] = 1'b0; req_wr[k] = 1'b0; req_size[k] = 2'd0; req_addr[k] = 32'h0;
            done_cnt[k] = 0; prev_rhs[k] = 1'b0; prev_wlast[k] = 1'b0;
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        for (int k = 0; k < 3; k++) begin
            chk(req_ready[k] && !mem_req[k] && !rsp_valid[k] && !wr_done[k] && !wr_err[k],
                "R10", "reset state",
                {27'd0, req_ready[k], mem_req[k], rsp_valid[k], wr_done[k], wr_err[k]}, 32'h10);
        end

        // R1/R6: line read, unaligned address, pass-through channel
        exp_read(32'h100, 8);
        send_req(0, 1'b0, 2'd2, 32'h104);
        drain();

        // R1/R7: line read on the buffered channel
        exp_read(32'h430, 4);
        send_req(1, 1'b0, 2'd0, 32'h43C);
        drain();

        // R2: line write, request size ignored
        for (int i = 0; i < 4; i++)
            exp_write(32'h200 + 32'(4 * i), 4'hF, 2'd2, 32'hC0DE_0000 + 32'(i), (i == 3), "R2");
        send_req(0, 1'b1, 2'd0, 32'h208);
        drain();
        chk(done_cnt[0] == 1, "R8", "line write completions", 32'(done_cnt[0]), 32'd1);

        // R3: single writes of each size
        exp_write(32'h301, 4'b0010, 2'd0, 32'h1122_3344, 1'b1, "R3");
        send_req(1, 1'b1, 2'd0, 32'h301);
        drain();
        exp_write(32'h302, 4'b1100, 2'd1, 32'h5566_7788, 1'b1, "R3");
        send_req(1, 1'b1, 2'd1, 32'h302);
        drain();
        exp_write(32'h304, 4'hF, 2'd2, 32'h99AA_BBCC, 1'b1, "R3");
        send_req(1, 1'b1, 2'd2, 32'h304);
        drain();
        chk(done_cnt[1] == 3, "R8", "single write completions", 32'(done_cnt[1]), 32'd3);

        // R4: write rejected on the no-write channel
        send_req(2, 1'b1, 2'd2, 32'h500);
        repeat (10) @(negedge clk);
        #2;
        chk(wr_err[2] == 1'b1, "R4", "error flag set", 32'(wr_err[2]), 32'd1);
        chk(req_ready[2] == 1'b1 && done_cnt[2] == 0, "R4", "entry removed, no completion",
            {31'd0, req_ready[2]}, 32'd1);
        exp_read(32'h520, 4);
        send_req(2, 1'b0, 2'd2, 32'h528);
        drain();
        #2;
        chk(wr_err[2] == 1'b1, "R4", "error flag sticky", 32'(wr_err[2]), 32'd1);

        // R5/R9: fill the access buffer while the memory stalls
        ack_en = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 5; i++) exp_read(32'h600 + 32'(32 * i), 8);
        for (int i = 0; i < 5; i++) send_req(0, 1'b0, 2'd2, 32'h600 + 32'(32 * i));
        @(negedge clk);
        #2;
        chk(req_ready[0] == 1'b0, "R5", "ready low when full", 32'(req_ready[0]), 32'd0);
        chk(mem_req[0] == 1'b1 && mem_addr[0] == 32'h600, "R9", "stalled beat offered",
            mem_addr[0], 32'h600);
        a0 = mem_addr[0];
        @(negedge clk);
        #2;
        chk(mem_req[0] == 1'b1 && mem_addr[0] == a0, "R9", "stalled beat held", mem_addr[0], a0);
        ack_en = 1'b1;
        drain();
        #2;
        chk(req_ready[0] == 1'b1, "R5", "ready after drain", 32'(req_ready[0]), 32'd1);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule